// File: doc/BRIEF.md
# LIN Master Receive-Frame Sequencer

This block is the master side of a LIN bus for frames in which the slave supplies the response. Software configures one frame with four byte writes to a transmit register. The block then sends the frame header through a byte-level serial engine: a break, the sync byte, then the protected identifier. After the header it collects the slave's response.

Each data byte goes to a receive register and raises a ready flag for software. Trailing CRC and checksum bytes, when enabled, are checked inside the block and never reach the receive register. A bit-time timeout guards the response phase.

Three sticky flags mark progress, and software clears each one: write taken, byte ready and frame complete. Error outputs report checksum, CRC and timeout faults.

Top module: `lin_rxframe_master`

## Requirements
- R1: After reset, every flag, error output, `brk_req`, `tx_valid` and `rx_data` is 0.
- R2: The four configuration writes are taken in this order:
  - the identifier byte, sent unchanged as the protected identifier;
  - the data byte count;
  - the control byte: bit 7 is the direction bit (0 = receive), bit 6 enables CRC, bit 5 enables checksum, and bits 3:0 are the timeout upper part;
  - the timeout lower part.
  
  When the fourth write is taken with bit 7 of the control byte at 0, `brk_req` is high in the next cycle.
- R3: If the fourth write is taken with control bit 7 at 1, no frame starts and the write sequence restarts at the identifier.
- R4: `txrdy` is 1 in the cycle after each accepted write and stays 1 until `clr_txrdy` is asserted. Writes made while a frame is in progress are ignored and do not set `txrdy`.
- R5: The header is sent in three steps, each held until its done input arrives:
  - `brk_req` stays high until `brk_done`;
  - `tx_valid` is then high with `tx_byte` = 0x55 until `tx_done`;
  - `tx_byte` is then the identifier byte until `tx_done`.
  
  `brk_req` and `tx_valid` are never high together.
- R6: Receive bytes that arrive before the identifier is sent are ignored. Each of the configured data bytes is loaded into `rx_data` and sets `rxrdy` in the next cycle; `rxrdy` stays 1 until `clr_rxrdy`.
- R7: After the data bytes, the CRC byte is received if enabled, then the checksum byte if enabled. Neither byte changes `rx_data` or `rxrdy`.
- R8: The expected checksum is the bitwise inverse of the 8-bit sum of the data bytes, with each carry added back in. A received checksum byte that differs sets `err_chk`.
- R9: The expected CRC is a CRC-8 with polynomial 0x07 and initial value 0x00, processed most significant bit first over the data bytes. A received CRC byte that differs sets `err_crc`.
- R10: `frc` is set in the cycle after the last field of the frame is received. If both trailing fields are disabled, the last field is the last data byte. If the count is 0 and both trailing fields are disabled, the last field is the identifier, sent on the `tx_done` that ends the header. `frc` stays 1 until `clr_frc`.
- R11: When the header ends, a counter loads {control[3:0], lower byte} and is decremented by each `bit_tick` during the response. On the tick that brings it to zero, `err_to` is set and the block returns to idle, ready for a new write sequence.
- R12: The error outputs are sticky and are cleared only when a new frame starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe for the transmit register |
| wr_data | input | 8 | Byte written to the transmit register |
| rx_data | output | 8 | Receive register |
| txrdy | output | 1 | Write-taken flag |
| rxrdy | output | 1 | Receive-byte-ready flag |
| frc | output | 1 | Frame-complete flag |
| clr_txrdy | input | 1 | Clears `txrdy` |
| clr_rxrdy | input | 1 | Clears `rxrdy` |
| clr_frc | input | 1 | Clears `frc` |
| brk_req | output | 1 | Break request to the serial engine |
| brk_done | input | 1 | Pulse: break has been sent |
| tx_valid | output | 1 | Byte to send is valid |
| tx_byte | output | 8 | Byte to send |
| tx_done | input | 1 | Pulse: byte has been sent |
| rx_valid | input | 1 | Pulse: a byte was received |
| rx_byte | input | 8 | Received byte |
| bit_tick | input | 1 | One pulse per bit time |
| err_chk | output | 1 | Checksum mismatch |
| err_crc | output | 1 | CRC mismatch |
| err_to | output | 1 | Response timeout |

## Verification
Random frames vary four things: the byte count from 1 to 8, random data, every combination of CRC and checksum enables, and a deliberate corruption of either trailing byte. These cases separate a correct trailing-field order and correct arithmetic from a swapped order or a wrong sum. Directed cases cover the following:
- a zero count with and without trailing fields, to show where `frc` falls;
- a control byte with the direction bit set, to show that the write sequence restarts;
- stray receive bytes during the header and writes during a frame;
- a timeout whose upper part is nonzero, which proves the two timeout parts are joined and that the error fires on the exact tick.

// File: rtl/lin_rxframe_master.sv
module lin_rxframe_master #(
  parameter logic [7:0] SYNC_BYTE = 8'h55,
  parameter logic [7:0] CRC_POLY  = 8'h07,
  parameter logic [7:0] CRC_INIT  = 8'h00
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  output logic [7:0] rx_data,
  output logic       txrdy,
  output logic       rxrdy,
  output logic       frc,
  input  logic       clr_txrdy,
  input  logic       clr_rxrdy,
  input  logic       clr_frc,
  output logic       brk_req,
  input  logic       brk_done,
  output logic       tx_valid,
  output logic [7:0] tx_byte,
  input  logic       tx_done,
  input  logic       rx_valid,
  input  logic [7:0] rx_byte,
  input  logic       bit_tick,
  output logic       err_chk,
  output logic       err_crc,
  output logic       err_to
);
  localparam logic [2:0] S_IDLE = 3'd0, S_BRK = 3'd1, S_SYNC = 3'd2, S_PID = 3'd3,
                         S_DATA = 3'd4, S_CRC = 3'd5, S_CHK = 3'd6;

  logic [2:0]  st;
  logic [1:0]  widx;
  logic [7:0]  id_q, cnt_q, ctl_q, tlo_q, left_q, sum_q, crc_q;
  logic [11:0] tcnt;

  function automatic logic [7:0] crc_step(input logic [7:0] c, input logic [7:0] d);
    logic [7:0] r;
    r = c ^ d;
    for (int i = 0; i < 8; i++) r = r[7] ? ((r << 1) ^ CRC_POLY) : (r << 1);
    return r;
  endfunction

  wire        idle     = (st == S_IDLE);
  wire        rcv_data = (st == S_DATA);
  wire        timed    = (st >= S_DATA);
  wire        to_hit   = timed && bit_tick && (tcnt <= 12'd1);
  wire        wr_ok    = wr_en && idle;
  wire [2:0]  tail_st  = ctl_q[6] ? S_CRC : (ctl_q[5] ? S_CHK : S_IDLE);
  wire [8:0]  sum9     = {1'b0, sum_q} + {1'b0, rx_byte};
  wire [7:0]  sum_nx   = sum9[7:0] + {7'd0, sum9[8]};
  wire [7:0]  crc_nx   = crc_step(crc_q, rx_byte);

  assign brk_req  = (st == S_BRK);
  assign tx_valid = (st == S_SYNC) || (st == S_PID);
  assign tx_byte  = (st == S_SYNC) ? SYNC_BYTE : id_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; widx <= '0;
      id_q <= '0; cnt_q <= '0; ctl_q <= '0; tlo_q <= '0;
      left_q <= '0; sum_q <= '0; crc_q <= CRC_INIT; tcnt <= '0;
      rx_data <= '0; txrdy <= 1'b0; rxrdy <= 1'b0; frc <= 1'b0;
      err_chk <= 1'b0; err_crc <= 1'b0; err_to <= 1'b0;
    end else begin
      if (clr_txrdy) txrdy <= 1'b0;
      if (clr_rxrdy) rxrdy <= 1'b0;
      if (clr_frc)   frc   <= 1'b0;
      if (wr_ok) begin
        txrdy <= 1'b1;
        widx  <= widx + 2'd1;
        case (widx)
          2'd0: id_q  <= wr_data;
          2'd1: cnt_q <= wr_data;
          2'd2: ctl_q <= wr_data;
          default: begin
            tlo_q <= wr_data;
            if (!ctl_q[7]) begin
              st <= S_BRK; left_q <= cnt_q;
              sum_q <= '0; crc_q <= CRC_INIT;
              err_chk <= 1'b0; err_crc <= 1'b0; err_to <= 1'b0;
            end
          end
        endcase
      end
      if (to_hit) begin
        err_to <= 1'b1;
        st     <= S_IDLE;
      end else begin
        if (timed && bit_tick) tcnt <= tcnt - 12'd1;
        case (st)
          S_BRK:  if (brk_done) st <= S_SYNC;
          S_SYNC: if (tx_done)  st <= S_PID;
          S_PID:  if (tx_done) begin
            tcnt <= {ctl_q[3:0], tlo_q};
            st   <= (cnt_q != 8'd0) ? S_DATA : tail_st;
            if (cnt_q == 8'd0 && tail_st == S_IDLE) frc <= 1'b1;
          end
          S_DATA: if (rx_valid) begin
            rx_data <= rx_byte;
            rxrdy   <= 1'b1;
            sum_q   <= sum_nx;
            crc_q   <= crc_nx;
            left_q  <= left_q - 8'd1;
            if (left_q == 8'd1) begin
              st <= tail_st;
              if (tail_st == S_IDLE) frc <= 1'b1;
            end
          end
          S_CRC: if (rx_valid) begin
            if (rx_byte != crc_q) err_crc <= 1'b1;
            st <= ctl_q[5] ? S_CHK : S_IDLE;
            if (!ctl_q[5]) frc <= 1'b1;
          end
          S_CHK: if (rx_valid) begin
            if (rx_byte != ~sum_q) err_chk <= 1'b1;
            st  <= S_IDLE;
            frc <= 1'b1;
          end
          default: ;
        endcase
      end
    end
  end
endmodule

module lin_rxframe_master_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic       idle,
  input logic       rcv_data,
  input logic       txrdy,
  input logic       rxrdy,
  input logic       frc,
  input logic       clr_txrdy,
  input logic       clr_frc,
  input logic       brk_req,
  input logic       tx_valid,
  input logic       rx_valid,
  input logic [7:0] rx_byte,
  input logic [7:0] rx_data,
  input logic       bit_tick,
  input logic       err_to
);
  AST_TXRDY_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && idle |=> txrdy); // R4
  AST_BUSY_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    !idle && !txrdy |=> !txrdy); // R4
  AST_BRK_TX_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    brk_req |-> !tx_valid); // R5
  AST_DATA_TO_RXREG: assert property (@(posedge clk) disable iff (!rst_n)
    rcv_data && rx_valid && !bit_tick |=> rxrdy && rx_data == $past(rx_byte)); // R6
  AST_RXREG_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !(rcv_data && rx_valid) |=> $stable(rx_data)); // R7
  AST_FRC_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    frc && !clr_frc |=> frc); // R10
  AST_TIMEOUT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_to) |-> idle); // R11
endmodule

bind lin_rxframe_master lin_rxframe_master_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .idle(idle), .rcv_data(rcv_data),
  .txrdy(txrdy), .rxrdy(rxrdy), .frc(frc), .clr_txrdy(clr_txrdy), .clr_frc(clr_frc),
  .brk_req(brk_req), .tx_valid(tx_valid), .rx_valid(rx_valid), .rx_byte(rx_byte),
  .rx_data(rx_data), .bit_tick(bit_tick), .err_to(err_to)
);

// File: tb/tb_lin_rxframe_master.sv
module tb_lin_rxframe_master;
  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 0, clr_txrdy = 0, clr_rxrdy = 0, clr_frc = 0;
  logic brk_done = 0, tx_done = 0, rx_valid = 0, bit_tick = 0;
  logic [7:0] wr_data = 0, rx_byte = 0;
  logic [7:0] rx_data, tx_byte;
  logic txrdy, rxrdy, frc, brk_req, tx_valid, err_chk, err_crc, err_to;
  int n_run = 0, n_fail = 0;
  bit finished = 0;
  logic [7:0] last_rx = 8'h00;

  always #5 clk = ~clk;

  lin_rxframe_master dut (.*);

  function automatic logic [7:0] exp_crc(input logic [7:0] c, input logic [7:0] d);
    logic [7:0] r = c ^ d;
    for (int i = 0; i < 8; i++) r = r[7] ? ((r << 1) ^ 8'h07) : (r << 1);
    return r;
  endfunction

  function automatic logic [7:0] exp_sum(input logic [7:0] s, input logic [7:0] d);
    int t = int'(s) + int'(d);
    if (t > 255) t = t - 255;
    return t[7:0];
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic pulse(ref logic s);
    @(negedge clk) s = 1'b1;
    @(negedge clk) s = 1'b0;
  endtask

  task automatic cfg_write(input logic [7:0] b);
    @(negedge clk) begin wr_en = 1; wr_data = b; end
    @(negedge clk) wr_en = 0;
    check("R4 txrdy after write", txrdy, 1);
    pulse(clr_txrdy);
    check("R4 txrdy cleared", txrdy, 0);
  endtask

  task automatic header(input logic [7:0] id);
    check("R2 break starts", brk_req, 1);
    check("R12 errors cleared on start", {err_chk, err_crc, err_to}, 0);
    pulse(wr_en);
    check("R4 busy write ignored", txrdy, 0);
    check("R5 no byte during break", tx_valid, 0);
    pulse(brk_done);
    check("R5 sync byte", {brk_req, tx_valid, tx_byte}, {2'b01, 8'h55});
    pulse(tx_done);
    check("R5 identifier byte", {tx_valid, tx_byte}, {1'b1, id});
    rx_byte = 8'hA7;
    pulse(rx_valid);
    check("R6 rx ignored during header", {rxrdy, rx_data}, {1'b0, last_rx});
    pulse(tx_done);
  endtask

  task automatic rx_one(input logic [7:0] b);
    rx_byte = b;
    pulse(rx_valid);
  endtask

  task automatic frame(input logic [7:0] id, input int n, input bit crc_en, input bit chk_en,
                       input bit bad_crc, input bit bad_chk);
    logic [7:0] s = 0, c = 0, d;
    cfg_write(id);
    cfg_write(n[7:0]);
    cfg_write({1'b0, crc_en, chk_en, 5'h0F});
    cfg_write(8'hFF);
    header(id);
    for (int i = 0; i < n; i++) begin
      d = 8'($urandom);
      rx_one(d);
      s = exp_sum(s, d); c = exp_crc(c, d); last_rx = d;
      check("R6 data to rx register", {rxrdy, rx_data}, {1'b1, d});
      pulse(clr_rxrdy);
      if (i < n - 1 || crc_en || chk_en) check("R10 no frc mid-frame", frc, 0);
    end
    if (crc_en) begin
      rx_one(c ^ {7'd0, bad_crc});
      check("R7 crc byte kept out", {rxrdy, rx_data}, {1'b0, last_rx});
    end
    if (chk_en) begin
      rx_one(~s ^ {7'd0, bad_chk});
      check("R7 checksum byte kept out", {rxrdy, rx_data}, {1'b0, last_rx});
    end
    check("R10 frc at frame end", frc, 1);
    check("R9 crc error flag", err_crc, crc_en & bad_crc);
    check("R8 checksum error flag", err_chk, chk_en & bad_chk);
    check("R12 errors sticky", err_to, 0);
    pulse(clr_frc);
    check("R10 frc cleared", frc, 0);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    check("R1 reset state", {txrdy, rxrdy, frc, brk_req, tx_valid, err_chk, err_crc, err_to, rx_data}, 0);
    rst_n = 1;
    @(negedge clk);
    check("R1 idle after reset", {brk_req, tx_valid}, 0);

    frame(8'h3C, 3, 1, 1, 0, 0);
    frame(8'hC1, 2, 1, 1, 1, 0);
    frame(8'h92, 4, 1, 1, 0, 1);
    frame(8'h11, 0, 1, 1, 0, 0);
    frame(8'h50, 1, 0, 0, 0, 0);
    for (int k = 0; k < 8; k++)
      frame(8'($urandom), 1 + int'($urandom % 8), 1'($urandom), 1'($urandom),
            1'($urandom % 3 == 0), 1'($urandom % 3 == 0));

    cfg_write(8'h22); cfg_write(8'h00); cfg_write(8'h0F); cfg_write(8'hFF);
    header(8'h22);
    check("R10 frc after header, nothing to receive", frc, 1);
    pulse(clr_frc);

    cfg_write(8'h44); cfg_write(8'h02); cfg_write(8'hE0); cfg_write(8'h10);
    repeat (3) @(negedge clk);
    check("R3 direction bit 1 starts nothing", {brk_req, tx_valid}, 0);
    frame(8'h44, 2, 1, 0, 0, 0);

    cfg_write(8'h7E); cfg_write(8'h02); cfg_write(8'h01); cfg_write(8'h02);
    header(8'h7E);
    for (int t = 0; t < 257; t++) pulse(bit_tick);
    check("R11 no timeout before count ends", err_to, 0);
    pulse(bit_tick);
    check("R11 timeout on final tick", err_to, 1);
    check("R11 frc not set on timeout", frc, 0);
    rx_one(8'h5A);
    check("R11 idle after timeout", {rxrdy, rx_data}, {1'b0, last_rx});
    frame(8'h0D, 1, 0, 1, 0, 0);

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule